// File: doc/BRIEF.md
# Gamma Setting Auto-Loader (I2C EEPROM Reader with Parity Retry)

After reset this block acts as an I2C bus master and fetches a set of gamma
correction settings from a serial EEPROM with no help from software. Two strap
inputs pick one of four 32-byte windows in the EEPROM. The block reads 22
consecutive bytes from the chosen window and rebuilds eleven 10-bit settings
from them, two bytes per setting. The first ten settings drive the gamma outputs
and the last one drives the common-voltage output.

Every stored byte carries an even-parity bit in its LSB. When a byte fails
parity, or the EEPROM does not acknowledge a header byte, the block closes the
transfer with a STOP and starts the whole read over. It keeps doing this until
one pass is clean. The visible settings change only after a clean pass, and at
that point the done flag rises and stays high. The bit timing comes from a clock
divider. Each SCL bit has four quarter-phases of `QUARTER_CYCLES` clocks each,
so a 100 MHz clock with the default value gives an SCL rate just under 400 kHz.

Top module: `eeprom_gamma_loader`

## Requirements
- R1: While `rst_n` is low, `load_done` is 0, every setting is 0, `scl_out` is 1 (released) and `sda_low` is 0.
- R2: Each pass sends the following, in order: START; the byte 0xA0 (device address 1010000 with all three chip-select bits zero, write); a word address equal to `strap_sel` × 32 (0x00, 0x20, 0x40 or 0x60); a repeated START; then 0xA1 (the same device, read).
- R3: A pass reads 22 consecutive bytes. The master drives ACK (SDA low) in the ninth clock after bytes 0 to 20. It drives NACK (SDA released) after byte 21 and then issues STOP. A clean pass therefore has exactly two STARTs and one STOP.
- R4: Setting k, where k runs from 0 to 10, is rebuilt from two bytes. Bits 9:3 come from bits 7:1 of byte 2k. Bits 2:0 come from bits 7:5 of byte 2k+1. Bits 4:1 of the odd bytes are ignored. Setting k appears at `setting_bus[10k+9:10k]`.
- R5: A byte is correct only if it holds an even number of ones, its parity bit (bit 0) included. After a byte with odd parity the master sends NACK and then STOP, and it restarts from R2. It repeats this until a pass has no error.
- R6: If the EEPROM leaves any header byte unacknowledged (SDA high in the ninth clock), the master issues STOP and restarts from R2.
- R7: `setting_bus` changes only in the cycle in which `load_done` rises, and only after a pass with no error. After that `load_done` stays 1 and the bus stays idle, with SCL released and SDA released.
- R8: Each low phase of SCL lasts at least 2 × `QUARTER_CYCLES` clock cycles, and so does each high phase.
- R9: `strap_sel` is sampled only while `rst_n` is low. A change to it after reset release has no effect on the word address sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; the read starts when it is released |
| strap_sel | input | 2 | Selects the EEPROM window base (× 32) |
| sda_in | input | 1 | Level sensed on the SDA line |
| scl_out | output | 1 | SCL level; 1 means released (pulled up) |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| setting_bus | output | 10 × NUM_SETTINGS | Committed settings; setting k sits at bits 10k+9:10k |
| load_done | output | 1 | High once a clean pass has been committed |

## Verification
The assertions assume that SCL is never held low by another device and that the SDA level seen at `sda_in` only changes while SCL is low, apart from the master's own START and STOP edges. The bench keeps to this. Its EEPROM model changes SDA only on falling SCL edges. It serves a memory image whose parity is correct unless a corruption is deliberately injected, and it can refuse to acknowledge the device address for a chosen number of passes. The strap is held steady during reset and is changed afterwards only in the run that checks it is ignored.

// File: rtl/egl_pkg.sv
// Package: shared types and constants for the gamma setting auto-loader.
// Assumes a standard 7-bit I2C EEPROM device address with chip selects zero.
package egl_pkg;

    // Low-level bus operations that the bit engine can carry out
    typedef enum logic [1:0] {
        PHY_START = 2'd0,
        PHY_STOP  = 2'd1,
        PHY_BIT   = 2'd2
    } phy_op_t;

    // EEPROM device address, chip-select bits all zero
    localparam logic [6:0] EEPROM_DEV = 7'h50;

    // Width of one rebuilt setting (7 high bits + 3 low bits)
    localparam int SETTING_W = 10;

endpackage

// File: rtl/egl_tick.sv
// Module: quarter-phase tick generator.
// Emits a one-cycle tick every Q clock cycles and restarts its count
// whenever restart is high, so that each bus phase lasts exactly Q cycles.
module egl_tick #(
    parameter int Q = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (Q > 1) ? $clog2(Q) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(Q - 1));

    // Count clocks within one quarter phase
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/egl_phy.sv
// Module: I2C bit engine.
// Runs one START, STOP or single data bit per command. Each command takes four
// quarter phases: SCL low, SDA set, SCL high, then a sample or the SDA edge for
// START/STOP. Assumes no clock stretching and that SDA only moves while SCL is
// low, except for START and STOP.
module egl_phy
    import egl_pkg::*;
#(
    parameter int QUARTER_CYCLES = 63
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  phy_op_t op,
    input  logic    tx_bit,
    output logic    ready,
    output logic    done,
    output logic    rx_bit,
    input  logic    sda_in,
    output logic    scl_out,
    output logic    sda_low
);
    logic       active;
    logic [1:0] ph;
    phy_op_t    op_q;
    logic       bit_q;
    logic       scl_q;
    logic       sda_q;
    logic [1:0] sync_q;
    logic       tick;
    logic       start_cmd;

    assign start_cmd = go && !active;
    assign ready     = !active;
    assign scl_out   = scl_q;
    assign sda_low   = !sda_q;

    egl_tick #(.Q(QUARTER_CYCLES)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_cmd),
        .tick    (tick)
    );

    // Two-stage synchronizer on the sensed SDA level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], sda_in};
        end
    end

    // Quarter-phase sequencer that drives SCL/SDA and samples the read bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= 2'd0;
            op_q   <= PHY_START;
            bit_q  <= 1'b0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            done   <= 1'b0;
            rx_bit <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_cmd) begin
                active <= 1'b1;
                ph     <= 2'd0;
                op_q   <= op;
                bit_q  <= tx_bit;
                scl_q  <= 1'b0;
            end else if (active && tick) begin
                if (ph == 2'd3) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    ph <= ph + 2'd1;
                    case (ph)
                        2'd0: begin
                            case (op_q)
                                PHY_START: sda_q <= 1'b1;
                                PHY_STOP:  sda_q <= 1'b0;
                                default:   sda_q <= bit_q;
                            endcase
                        end
                        2'd1: scl_q <= 1'b1;
                        default: begin
                            case (op_q)
                                PHY_START: sda_q <= 1'b0;
                                PHY_STOP:  sda_q <= 1'b1;
                                default:   rx_bit <= sync_q[1];
                            endcase
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/egl_seq.sv
// Module: auto-read sequencer.
// Builds the header (device write, word address, repeated start, device read),
// reads 2*NUM_SETTINGS bytes, checks even parity per byte and fills a shadow
// copy of the settings. A parity error or a missing slave ACK ends the pass
// with STOP and restarts it. A clean pass raises commit for one cycle.
// Assumes strap_sel is stable while rst_n is low.
module egl_seq
    import egl_pkg::*;
#(
    parameter int NUM_SETTINGS = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        strap_sel,
    input  logic                              phy_ready,
    input  logic                              phy_done,
    input  logic                              phy_rx,
    output logic                              phy_go,
    output phy_op_t                           phy_op,
    output logic                              phy_bit,
    output logic [NUM_SETTINGS*SETTING_W-1:0] shadow_flat,
    output logic                              commit
);
    localparam int NBYTES = 2 * NUM_SETTINGS;
    localparam int BW     = $clog2(NBYTES);

    typedef enum logic [2:0] {
        SQ_START, SQ_TXBIT, SQ_TXACK, SQ_RSTART,
        SQ_RXBIT, SQ_RXACK, SQ_STOP,  SQ_DONE
    } sq_state_t;

    sq_state_t                               st;
    logic                                    pend;
    logic [1:0]                              hdr_step;
    logic [7:0]                              shreg;
    logic [2:0]                              bitn;
    logic [BW-1:0]                           byte_idx;
    logic                                    fail;
    logic [1:0]                              strap_q;
    logic [NUM_SETTINGS-1:0][SETTING_W-1:0]  shadow;
    logic                                    rx_bad;
    logic                                    last_byte;
    logic [7:0]                              word_addr;

    assign rx_bad    = ^shreg;
    assign last_byte = (byte_idx == BW'(NBYTES - 1));
    assign word_addr = {1'b0, strap_q, 5'b00000};
    assign phy_go    = !pend && phy_ready && (st != SQ_DONE);

    // Flatten the shadow copy for the register bank
    for (genvar g = 0; g < NUM_SETTINGS; g++) begin : g_flat
        assign shadow_flat[g*SETTING_W +: SETTING_W] = shadow[g];
    end

    // Choose the bus operation for the current state
    always_comb begin
        phy_op  = PHY_BIT;
        phy_bit = 1'b1;
        case (st)
            SQ_START, SQ_RSTART: phy_op = PHY_START;
            SQ_STOP:             phy_op = PHY_STOP;
            SQ_TXBIT:            phy_bit = shreg[7];
            SQ_RXACK:            phy_bit = rx_bad || last_byte;
            default:             phy_bit = 1'b1;
        endcase
    end

    // Step through header, data bytes, parity checks and retries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_START;
            pend     <= 1'b0;
            hdr_step <= 2'd0;
            shreg    <= 8'h00;
            bitn     <= 3'd0;
            byte_idx <= '0;
            fail     <= 1'b0;
            strap_q  <= strap_sel;
            shadow   <= '0;
            commit   <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (phy_go) begin
                pend <= 1'b1;
            end
            if (phy_done) begin
                pend <= 1'b0;
                case (st)
                    SQ_START: begin
                        hdr_step <= 2'd0;
                        shreg    <= {EEPROM_DEV, 1'b0};
                        bitn     <= 3'd0;
                        fail     <= 1'b0;
                        st       <= SQ_TXBIT;
                    end
                    SQ_TXBIT: begin
                        shreg <= {shreg[6:0], 1'b0};
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            st <= SQ_TXACK;
                        end
                    end
                    SQ_TXACK: begin
                        if (phy_rx) begin
                            fail <= 1'b1;
                            st   <= SQ_STOP;
                        end else if (hdr_step == 2'd0) begin
                            hdr_step <= 2'd1;
                            shreg    <= word_addr;
                            st       <= SQ_TXBIT;
                        end else if (hdr_step == 2'd1) begin
                            st <= SQ_RSTART;
                        end else begin
                            bitn     <= 3'd0;
                            byte_idx <= '0;
                            st       <= SQ_RXBIT;
                        end
                    end
                    SQ_RSTART: begin
                        hdr_step <= 2'd2;
                        shreg    <= {EEPROM_DEV, 1'b1};
                        bitn     <= 3'd0;
                        st       <= SQ_TXBIT;
                    end
                    SQ_RXBIT: begin
                        shreg <= {shreg[6:0], phy_rx};
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            st <= SQ_RXACK;
                        end
                    end
                    SQ_RXACK: begin
                        if (rx_bad) begin
                            fail <= 1'b1;
                            st   <= SQ_STOP;
                        end else begin
                            if (byte_idx[0]) begin
                                shadow[byte_idx[BW-1:1]][2:0] <= shreg[7:5];
                            end else begin
                                shadow[byte_idx[BW-1:1]][9:3] <= shreg[7:1];
                            end
                            if (last_byte) begin
                                fail <= 1'b0;
                                st   <= SQ_STOP;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                st       <= SQ_RXBIT;
                            end
                        end
                    end
                    SQ_STOP: begin
                        if (fail) begin
                            st <= SQ_START;
                        end else begin
                            commit <= 1'b1;
                            st     <= SQ_DONE;
                        end
                    end
                    default: st <= SQ_DONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/egl_bank.sv
// Module: visible setting registers.
// Copies the whole shadow in the commit cycle and raises a sticky done flag
// in the same cycle. Assumes commit pulses at most once per reset.
module egl_bank
    import egl_pkg::*;
#(
    parameter int NUM_SETTINGS = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [NUM_SETTINGS*SETTING_W-1:0] shadow_flat,
    output logic [NUM_SETTINGS*SETTING_W-1:0] setting_bus,
    output logic                              load_done
);
    for (genvar g = 0; g < NUM_SETTINGS; g++) begin : g_reg
        // Hold one committed setting
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                setting_bus[g*SETTING_W +: SETTING_W] <= '0;
            end else if (commit) begin
                setting_bus[g*SETTING_W +: SETTING_W] <= shadow_flat[g*SETTING_W +: SETTING_W];
            end
        end
    end

    // Sticky completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_done <= 1'b0;
        end else if (commit) begin
            load_done <= 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_gamma_loader.sv
// Module: gamma setting auto-loader top.
// Wires the sequencer, the bit engine and the register bank together. SCL is
// driven push-pull as a level (1 = released); SDA is open-drain through
// sda_low. Assumes a single EEPROM on the bus that does not stretch SCL.
module eeprom_gamma_loader
    import egl_pkg::*;
#(
    parameter int QUARTER_CYCLES = 63,
    parameter int NUM_SETTINGS   = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        strap_sel,
    input  logic                              sda_in,
    output logic                              scl_out,
    output logic                              sda_low,
    output logic [NUM_SETTINGS*SETTING_W-1:0] setting_bus,
    output logic                              load_done
);
    logic                              phy_go;
    phy_op_t                           phy_op;
    logic                              phy_bit;
    logic                              phy_ready;
    logic                              phy_done;
    logic                              phy_rx;
    logic                              commit;
    logic [NUM_SETTINGS*SETTING_W-1:0] shadow_flat;

    egl_seq #(.NUM_SETTINGS(NUM_SETTINGS)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_sel   (strap_sel),
        .phy_ready   (phy_ready),
        .phy_done    (phy_done),
        .phy_rx      (phy_rx),
        .phy_go      (phy_go),
        .phy_op      (phy_op),
        .phy_bit     (phy_bit),
        .shadow_flat (shadow_flat),
        .commit      (commit)
    );

    egl_phy #(.QUARTER_CYCLES(QUARTER_CYCLES)) phy_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (phy_go),
        .op      (phy_op),
        .tx_bit  (phy_bit),
        .ready   (phy_ready),
        .done    (phy_done),
        .rx_bit  (phy_rx),
        .sda_in  (sda_in),
        .scl_out (scl_out),
        .sda_low (sda_low)
    );

    egl_bank #(.NUM_SETTINGS(NUM_SETTINGS)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .shadow_flat (shadow_flat),
        .setting_bus (setting_bus),
        .load_done   (load_done)
    );
endmodule

// File: rtl/egl_checker.sv
// Module: property checker bound to the auto-loader top.
// Watches the bus pins and the committed outputs. Assumes SCL is never held
// low by another device.
module egl_checker
    import egl_pkg::*;
#(
    parameter int QUARTER_CYCLES = 63,
    parameter int NUM_SETTINGS   = 11
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              scl_out,
    input logic                              sda_low,
    input logic [NUM_SETTINGS*SETTING_W-1:0] setting_bus,
    input logic                              load_done
);
    localparam int MIN_PHASE = 2 * QUARTER_CYCLES;
    localparam int CW        = $clog2(MIN_PHASE + 2) + 1;
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic [CW-1:0] low_run;
    logic [CW-1:0] high_run;
    logic          seen_rise;

    // Measure how long SCL has stayed in its present level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            high_run  <= '0;
            seen_rise <= 1'b0;
        end else begin
            if (scl_out) begin
                low_run  <= '0;
                high_run <= (high_run == SAT) ? SAT : high_run + 1'b1;
            end else begin
                high_run <= '0;
                low_run  <= (low_run == SAT) ? SAT : low_run + 1'b1;
            end
            if (scl_out && low_run != '0) begin
                seen_rise <= 1'b1;
            end
        end
    end

    // R7: completion flag never drops once raised
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R7: settings move only together with the rise of the done flag
    a_r7_settings_move_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(setting_bus) |-> $rose(load_done));

    // R7: bus idle once done
    a_r7_bus_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (scl_out && !sda_low));

    // R8: SCL low phase long enough
    a_r8_scl_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_out) |-> (low_run >= CW'(MIN_PHASE - 1)));

    // R8: SCL high phase long enough (after the first rise since reset)
    a_r8_scl_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_out) && seen_rise) |-> (high_run >= CW'(MIN_PHASE - 1)));
endmodule

bind eeprom_gamma_loader egl_checker #(
    .QUARTER_CYCLES (QUARTER_CYCLES),
    .NUM_SETTINGS   (NUM_SETTINGS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_out     (scl_out),
    .sda_low     (sda_low),
    .setting_bus (setting_bus),
    .load_done   (load_done)
);

// File: tb/eeprom_gamma_loader_tb_top.sv
// Bench: EEPROM model plus strap sweep, parity and ACK fault runs.
module eeprom_gamma_loader_tb_top;
    localparam int Q    = 4;
    localparam int NSET = 11;
    localparam int NB   = 2 * NSET;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        strap_sel = 2'd0;
    logic              scl_out;
    logic              sda_low;
    logic [NSET*10-1:0] setting_bus;
    logic              load_done;
    logic              slv_low = 1'b0;
    wire               sda_line = !(sda_low === 1'b1 || slv_low);
    wire               scl_line = scl_out;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    eeprom_gamma_loader #(.QUARTER_CYCLES(Q), .NUM_SETTINGS(NSET)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_sel   (strap_sel),
        .sda_in      (sda_line),
        .scl_out     (scl_out),
        .sda_low     (sda_low),
        .setting_bus (setting_bus),
        .load_done   (load_done)
    );

    // ---------------- EEPROM model ----------------
    function automatic logic [7:0] byte_at(input logic [6:0] a);
        logic [6:0] d;
        d = a * 7'd37 + 7'd11;
        return {d, ^d};
    endfunction

    int         mode = 0;      // 0 idle, 1 address, 2 word, 3 wait, 4 read
    int         cnt = 0;
    logic [7:0] rx = 8'h00;
    logic [6:0] ptr = 7'd0;
    bit         ack_pending = 1'b0;
    int         start_cnt = 0, stop_cnt = 0, rd_addr_cnt = 0;
    logic [7:0] last_wdev = 8'h00, last_rdev = 8'h00, last_word = 8'hFF;
    int         nack_budget = 0, corrupt_budget = 0, corrupt_idx = 0;
    int         byte_in_pass = 0;
    bit         bad_byte_nacked = 1'b0;
    logic       master_ack [NB];

    always @(negedge sda_line) begin
        if (scl_line === 1'b1) begin
            start_cnt++;
            mode = 1; cnt = 0; ack_pending = 1'b0; slv_low = 1'b0;
        end
    end

    always @(posedge sda_line) begin
        if (scl_line === 1'b1) begin
            stop_cnt++;
            mode = 0; slv_low = 1'b0;
        end
    end

    always @(posedge scl_line) begin
        if (cnt < 8) begin
            rx = {rx[6:0], sda_line};
            cnt++;
            if (cnt == 8) begin
                if (mode == 1) begin
                    if (rx[7:1] == 7'h50) begin
                        if (nack_budget > 0) begin
                            nack_budget--; mode = 0;
                        end else begin
                            ack_pending = 1'b1;
                            if (rx[0]) begin
                                mode = 4; rd_addr_cnt++; last_rdev = rx; byte_in_pass = 0;
                            end else begin
                                mode = 2; last_wdev = rx;
                            end
                        end
                    end else begin
                        mode = 0;
                    end
                end else if (mode == 2) begin
                    ptr = rx[6:0]; last_word = rx; ack_pending = 1'b1; mode = 3;
                end
            end
        end else begin
            if (ack_pending) begin
                ack_pending = 1'b0;
            end else if (mode == 4) begin
                if (corrupt_budget > 0 && byte_in_pass == corrupt_idx) begin
                    corrupt_budget--;
                    if (sda_line) bad_byte_nacked = 1'b1;
                end
                if (byte_in_pass < NB) master_ack[byte_in_pass] = sda_line;
                byte_in_pass++;
                ptr = ptr + 7'd1;
                if (sda_line) mode = 0;
            end
            cnt = 0;
        end
    end

    always @(negedge scl_line) begin
        logic [7:0] b;
        if (ack_pending) begin
            slv_low = 1'b1;
        end else if (mode == 4 && cnt < 8) begin
            b = byte_at(ptr);
            if (corrupt_budget > 0 && byte_in_pass == corrupt_idx) b = b ^ 8'h10;
            slv_low = !b[7-cnt];
        end else begin
            slv_low = 1'b0;
        end
    end

    // ---------------- SCL timing monitor (R8) ----------------
    time last_fall = 0, last_rise = 0;
    bit  fall_seen = 1'b0, rise_seen = 1'b0;
    time min_low = 0, min_high = 0;

    always @(posedge scl_line) begin
        if (fall_seen && (min_low == 0 || $time - last_fall < min_low)) min_low = $time - last_fall;
        last_rise = $time; rise_seen = 1'b1;
    end
    always @(negedge scl_line) begin
        if (rise_seen && (min_high == 0 || $time - last_rise < min_high)) min_high = $time - last_rise;
        last_fall = $time; fall_seen = 1'b1;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_setting(input logic [6:0] base, input int k);
        logic [7:0] hi, lo;
        hi = byte_at(base + 7'(2*k));
        lo = byte_at(base + 7'(2*k + 1));
        return {hi[7:1], lo[7:5]};
    endfunction

    task automatic start_run(input logic [1:0] s, input int nack, input int corrupt, input int cidx);
        @(negedge clk);
        rst_n = 1'b0; strap_sel = s;
        mode = 0; cnt = 0; ack_pending = 1'b0; slv_low = 1'b0;
        start_cnt = 0; stop_cnt = 0; rd_addr_cnt = 0;
        last_wdev = 8'h00; last_rdev = 8'h00; last_word = 8'hFF;
        nack_budget = nack; corrupt_budget = corrupt; corrupt_idx = cidx;
        bad_byte_nacked = 1'b0;
        fall_seen = 1'b0; rise_seen = 1'b0; min_low = 0; min_high = 0;
        for (int i = 0; i < NB; i++) master_ack[i] = 1'bx;
        repeat (4) @(negedge clk);
        // R1: state held in reset
        chk(load_done === 1'b0, "R1", "load_done in reset", load_done, 0);
        chk(setting_bus === '0, "R1", "settings in reset", setting_bus[63:0], 0);
        chk(scl_out === 1'b1 && sda_low === 1'b0, "R1", "bus released in reset",
            {scl_out, sda_low}, 2'b10);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (load_done !== 1'b1 && n < 40000) begin
            @(negedge clk); n++;
        end
        chk(load_done === 1'b1, "R7", "watchdog: load_done reached", load_done, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pass(input logic [1:0] s, input int passes, input int starts, input int stops);
        logic [6:0] base;
        base = {s, 5'b00000};
        chk(last_wdev == 8'hA0, "R2", "device write byte", last_wdev, 8'hA0);
        chk(last_rdev == 8'hA1, "R2", "device read byte", last_rdev, 8'hA1);
        chk(last_word == {1'b0, base}, "R9", "word address from strap", last_word, {1'b0, base});
        chk(rd_addr_cnt == passes, "R5", "read passes", rd_addr_cnt, passes);
        chk(start_cnt == starts, "R3", "START count", start_cnt, starts);
        chk(stop_cnt == stops, "R3", "STOP count", stop_cnt, stops);
        for (int i = 0; i < NB; i++) begin
            chk(master_ack[i] === (i == NB - 1), "R3", $sformatf("master ack after byte %0d", i),
                master_ack[i], (i == NB - 1));
        end
        for (int k = 0; k < NSET; k++) begin
            chk(setting_bus[k*10 +: 10] == exp_setting(base, k), "R4",
                $sformatf("setting %0d", k), setting_bus[k*10 +: 10], exp_setting(base, k));
        end
        chk(scl_out === 1'b1 && sda_low === 1'b0, "R7", "bus idle after done",
            {scl_out, sda_low}, 2'b10);
        chk(min_low >= 2 * Q * 10, "R8", "minimum SCL low (ns)", min_low, 2 * Q * 10);
        chk(min_high >= 2 * Q * 10, "R8", "minimum SCL high (ns)", min_high, 2 * Q * 10);
    endtask

    // ---------------- scenario ----------------
    initial begin
        // Strap sweep, clean memory
        for (int s = 0; s < 4; s++) begin
            start_run(2'(s), 0, 0, 0);
            wait_done();
            check_pass(2'(s), 1, 2, 1);
        end

        // R5: corrupted byte 7 for two passes, settings untouched meanwhile
        start_run(2'd2, 0, 2, 7);
        begin
            int n;
            n = 0;
            while (rd_addr_cnt < 2 && n < 40000) begin @(negedge clk); n++; end
        end
        chk(load_done === 1'b0, "R5", "no done during retry", load_done, 0);
        chk(setting_bus === '0, "R5", "settings held during retry", setting_bus[63:0], 0);
        wait_done();
        chk(bad_byte_nacked, "R5", "bad byte NACKed", bad_byte_nacked, 1);
        check_pass(2'd2, 3, 6, 3);

        // R5: error on the final byte
        start_run(2'd3, 0, 1, NB - 1);
        wait_done();
        check_pass(2'd3, 2, 4, 2);

        // R6 and R9: device address refused once; strap changed after release
        start_run(2'd1, 1, 0, 0);
        @(negedge clk);
        strap_sel = 2'd2;
        wait_done();
        check_pass(2'd1, 1, 3, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule